// File: doc/BRIEF.md
# Camera Link Base Video Receiver

This block sits directly behind an external Camera Link Base deserializer and runs on the recovered pixel clock, which may lie anywhere between 20 MHz and 85 MHz. Each clock it takes one 28-bit parallel word. The word holds up to 24 bits of pixel data, three level-type qualifiers for frame, line and data, and one spare bit. Three nested envelopes mark the accepted pixels. The frame envelope encloses every valid line. The line envelope encloses every valid pixel of its line. The data qualifier marks the individual pixels inside a line.

The receiver turns these envelopes into a packetized video stream in AXI4-Stream style. A start-of-frame marker goes out on `m_tuser` and an end-of-line marker goes out on `m_tlast`. The end of a line is only known once the line envelope drops, so each accepted pixel waits in a one-word holding register until either the next pixel or the line end decides its end-of-line bit.

The block also measures the frame. It reports the pixel count of the most recent line and the line count of the most recent frame. It flags lines whose length changes within a frame and line envelopes that appear outside a frame. The camera side is never stalled. A beat that downstream does not accept is lost, and a sticky overflow flag records the loss.

Top module: `cl_base_rx`

## Requirements
- R1: After reset, `m_tvalid`, `m_tuser`, `m_tlast`, `line_pixels`, `frame_lines` and all three error flags are 0.
- R2: Input word mapping: bits 23..0 carry the pixel, bit 24 is the line qualifier, bit 25 the frame qualifier, bit 26 the data qualifier, and bit 27 is spare. The spare bit has no effect on any output. `m_tdata` carries the pixel bits of the accepted words, in arrival order and unaltered.
- R3: A word becomes a stream beat only when the frame, line and data qualifiers are all 1 in that word. A word with any of the three at 0 produces no beat.
- R4: `m_tuser` is 1 on the first beat after each rising edge of the frame qualifier, and 0 on every other beat.
- R5: `m_tlast` is 1 on the last accepted pixel of each line, and on no other beat. That beat is emitted after the line qualifier falls. A line of one pixel carries both `m_tuser` (if it is the first line of the frame) and `m_tlast` on the same beat.
- R6: At each falling edge of the line qualifier, `line_pixels` takes the number of pixels accepted in that line.
- R7: At each falling edge of the frame qualifier, `frame_lines` takes the number of line envelopes seen in that frame.
- R8: `err_line_len` becomes 1 when a line's pixel count differs from that of the previous line of the same frame. It returns to 0 at the next rising edge of the frame qualifier.
- R9: `err_framing` becomes 1, and stays 1 until reset, when the line qualifier is 1 while the frame qualifier is 0.
- R10: A beat presented with `m_tready` at 0 sets `err_overflow`, which stays 1 until reset. Beats keep being produced at the camera's pace whatever `m_tready` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock from the deserializer |
| rst_n | input | 1 | Active-low asynchronous reset |
| cl_word | input | 28 | Parallel word from the deserializer |
| m_tready | input | 1 | Downstream ready |
| m_tdata | output | 24 | Pixel data of the beat |
| m_tvalid | output | 1 | Beat present this cycle |
| m_tuser | output | 1 | First beat of a frame |
| m_tlast | output | 1 | Last beat of a line |
| line_pixels | output | 16 | Pixel count of the most recent line |
| frame_lines | output | 16 | Line count of the most recent frame |
| err_line_len | output | 1 | Line length changed within the frame |
| err_framing | output | 1 | Line envelope seen outside a frame (sticky) |
| err_overflow | output | 1 | A beat was dropped for lack of ready (sticky) |

## Verification
The hardest case to reach is an accepted pixel whose end-of-line status is still unknown because the data qualifier has gone low while the line envelope stays high. That pixel has to wait in the holding register for several cycles and then leave with its end-of-line marker only when the envelope falls. The stimulus table therefore includes frames that insert data-qualifier gaps inside each line and idle cycles just before each line end. It also includes a frame made of a single one-pixel line, so that both markers fall on the same held beat. Directed runs send two frames with no reset between them, to show that the start marker repeats and that the length error clears. They also drive a line envelope with the frame envelope low, to show that the framing error is raised and that no beat appears.

// File: rtl/cl_base_rx_pkg.sv
package cl_base_rx_pkg;

   localparam int WORD_W = 28;

   // envelope events decoded from one registered input word
   typedef struct packed {
      logic accept;     // pixel qualified by all three envelopes
      logic fv_rise;
      logic fv_fall;
      logic lv_fall;
      logic lv_orphan;  // line envelope without frame envelope
   } cl_evt_t;

   function automatic bit bit_in_word(int pos);
      return (pos >= 0) && (pos < WORD_W);
   endfunction

endpackage

// File: rtl/cl_base_rx_unpack.sv
module cl_base_rx_unpack
   import cl_base_rx_pkg::*;
#(
   parameter int PIX_W   = 24,
   parameter int PIX_LSB = 0,
   parameter int LV_BIT  = 24,
   parameter int FV_BIT  = 25,
   parameter int DV_BIT  = 26,
   parameter bit IN_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word,
   output logic [PIX_W-1:0]  pix,
   output cl_evt_t           evt
);

   logic [WORD_W-1:0] w;
   logic fv, lv, dv;
   logic fv_d, lv_d;

   generate
      if (IN_REG) begin : g_in_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) w <= '0;
            else        w <= word;
         end
      end else begin : g_in_pass
         assign w = word;
      end
   endgenerate

   assign pix = w[PIX_LSB +: PIX_W];
   assign fv  = w[FV_BIT];
   assign lv  = w[LV_BIT];
   assign dv  = w[DV_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fv_d <= 1'b0;
         lv_d <= 1'b0;
      end else begin
         fv_d <= fv;
         lv_d <= lv;
      end
   end

   always_comb begin
      evt.accept    = fv & lv & dv;
      evt.fv_rise   = fv & ~fv_d;
      evt.fv_fall   = ~fv & fv_d;
      evt.lv_fall   = ~lv & lv_d;
      evt.lv_orphan = lv & ~fv;
   end

endmodule

// File: rtl/cl_base_rx_framer.sv
module cl_base_rx_framer
   import cl_base_rx_pkg::*;
#(
   parameter int PIX_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cl_evt_t          evt,
   input  logic [PIX_W-1:0] pix,
   output logic [PIX_W-1:0] tdata,
   output logic             tvalid,
   output logic             tuser,
   output logic             tlast
);

   logic [PIX_W-1:0] hold_pix;
   logic             hold_vld;
   logic             hold_sof;
   logic             sof_pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_pix <= '0;
         hold_vld <= 1'b0;
         hold_sof <= 1'b0;
         sof_pend <= 1'b0;
         tdata    <= '0;
         tvalid   <= 1'b0;
         tuser    <= 1'b0;
         tlast    <= 1'b0;
      end else begin
         tvalid <= 1'b0;
         tuser  <= 1'b0;
         tlast  <= 1'b0;
         if (evt.fv_rise) sof_pend <= 1'b1;
         if (evt.accept) begin
            // a new pixel proves the held one was not the line's last
            if (hold_vld) begin
               tvalid <= 1'b1;
               tdata  <= hold_pix;
               tuser  <= hold_sof;
            end
            hold_pix <= pix;
            hold_vld <= 1'b1;
            hold_sof <= sof_pend | evt.fv_rise;
            sof_pend <= 1'b0;
         end else if (evt.lv_fall && hold_vld) begin
            tvalid   <= 1'b1;
            tdata    <= hold_pix;
            tuser    <= hold_sof;
            tlast    <= 1'b1;
            hold_vld <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cl_base_rx_counter.sv
module cl_base_rx_counter
   import cl_base_rx_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  cl_evt_t          evt,
   output logic [CNT_W-1:0] line_pixels,
   output logic [CNT_W-1:0] frame_lines,
   output logic             err_len
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] pix_cnt;
   logic [CNT_W-1:0] line_cnt;
   logic [CNT_W-1:0] prev_len;
   logic             have_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_cnt     <= '0;
         line_cnt    <= '0;
         prev_len    <= '0;
         have_prev   <= 1'b0;
         line_pixels <= '0;
         frame_lines <= '0;
         err_len     <= 1'b0;
      end else begin
         if (evt.accept) pix_cnt <= pix_cnt + ONE;
         if (evt.lv_fall) begin
            line_pixels <= pix_cnt;
            prev_len    <= pix_cnt;
            pix_cnt     <= '0;
            have_prev   <= 1'b1;
            line_cnt    <= line_cnt + ONE;
            if (have_prev && (pix_cnt != prev_len)) err_len <= 1'b1;
         end
         if (evt.fv_fall)
            frame_lines <= evt.lv_fall ? line_cnt + ONE : line_cnt;
         if (evt.fv_rise) begin
            line_cnt  <= '0;
            have_prev <= 1'b0;
            err_len   <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/cl_base_rx.sv
module cl_base_rx
   import cl_base_rx_pkg::*;
#(
   parameter int PIX_W   = 24,
   parameter int PIX_LSB = 0,
   parameter int LV_BIT  = 24,
   parameter int FV_BIT  = 25,
   parameter int DV_BIT  = 26,
   parameter int CNT_W   = 16,
   parameter bit IN_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [27:0]       cl_word,
   input  logic              m_tready,
   output logic [PIX_W-1:0]  m_tdata,
   output logic              m_tvalid,
   output logic              m_tuser,
   output logic              m_tlast,
   output logic [CNT_W-1:0]  line_pixels,
   output logic [CNT_W-1:0]  frame_lines,
   output logic              err_line_len,
   output logic              err_framing,
   output logic              err_overflow
);

   localparam int PIX_MSB = PIX_LSB + PIX_W - 1;

   generate
      if (PIX_W < 1 || PIX_W > 24) begin : g_bad_width
         $error("pixel width must be 1 to 24");
      end
      if (!bit_in_word(PIX_LSB) || !bit_in_word(PIX_MSB)) begin : g_bad_pix
         $error("pixel field outside the input word");
      end
      if (!bit_in_word(FV_BIT) || !bit_in_word(LV_BIT) || !bit_in_word(DV_BIT)) begin : g_bad_sync
         $error("qualifier bit outside the input word");
      end
      if (FV_BIT == LV_BIT || FV_BIT == DV_BIT || LV_BIT == DV_BIT) begin : g_dup_sync
         $error("qualifier bits must differ");
      end
      if ((FV_BIT >= PIX_LSB && FV_BIT <= PIX_MSB) ||
          (LV_BIT >= PIX_LSB && LV_BIT <= PIX_MSB) ||
          (DV_BIT >= PIX_LSB && DV_BIT <= PIX_MSB)) begin : g_overlap
         $error("qualifier bit overlaps pixel field");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("counter width too small");
      end
   endgenerate

   cl_evt_t          evt;
   logic [PIX_W-1:0] pix;

   cl_base_rx_unpack #(
      .PIX_W(PIX_W), .PIX_LSB(PIX_LSB), .LV_BIT(LV_BIT),
      .FV_BIT(FV_BIT), .DV_BIT(DV_BIT), .IN_REG(IN_REG)
   ) u_unpack (
      .clk(clk), .rst_n(rst_n), .word(cl_word), .pix(pix), .evt(evt)
   );

   cl_base_rx_framer #(.PIX_W(PIX_W)) u_framer (
      .clk(clk), .rst_n(rst_n), .evt(evt), .pix(pix),
      .tdata(m_tdata), .tvalid(m_tvalid), .tuser(m_tuser), .tlast(m_tlast)
   );

   cl_base_rx_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .evt(evt),
      .line_pixels(line_pixels), .frame_lines(frame_lines), .err_len(err_line_len)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_framing  <= 1'b0;
         err_overflow <= 1'b0;
      end else begin
         if (evt.lv_orphan) err_framing <= 1'b1;
         if (m_tvalid && !m_tready) err_overflow <= 1'b1;
      end
   end

endmodule

// File: rtl/cl_base_rx_chk.sv
module cl_base_rx_chk (
   input logic clk,
   input logic rst_n,
   input logic m_tvalid,
   input logic m_tready,
   input logic m_tuser,
   input logic m_tlast,
   input logic orphan,
   input logic fv_rise,
   input logic err_line_len,
   input logic err_framing,
   input logic err_overflow
);

   // R4
   tuser_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tuser |-> m_tvalid);

   // R5
   tlast_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_tlast |-> m_tvalid);

   // R10
   drop_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (m_tvalid && !m_tready) |=> err_overflow);

   // R10
   overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |=> err_overflow);

   // R9
   orphan_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      orphan |=> err_framing);

   // R9
   framing_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_framing |=> err_framing);

   // R8
   len_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fv_rise |=> !err_line_len);

endmodule

bind cl_base_rx cl_base_rx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .m_tvalid(m_tvalid), .m_tready(m_tready),
   .m_tuser(m_tuser), .m_tlast(m_tlast), .orphan(evt.lv_orphan),
   .fv_rise(evt.fv_rise), .err_line_len(err_line_len),
   .err_framing(err_framing), .err_overflow(err_overflow)
);

// File: tb/cl_base_rx_tb.sv
module cl_base_rx_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [27:0] cl_word = '0;
   logic        m_tready = 1'b1;
   logic [23:0] m_tdata;
   logic        m_tvalid, m_tuser, m_tlast;
   logic [15:0] line_pixels, frame_lines;
   logic        err_line_len, err_framing, err_overflow;

   always #2 clk = ~clk;

   cl_base_rx u_dut (
      .clk(clk), .rst_n(rst_n), .cl_word(cl_word), .m_tready(m_tready),
      .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tuser(m_tuser), .m_tlast(m_tlast),
      .line_pixels(line_pixels), .frame_lines(frame_lines),
      .err_line_len(err_line_len), .err_framing(err_framing), .err_overflow(err_overflow)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // fields: lines[25:18] ppl[17:10] gap[9:6] extra[5:2] ready[1] exp_len_err[0]
   localparam logic [25:0] VEC [6] = '{
      {8'd3, 8'd8, 4'd0, 4'd0, 1'b1, 1'b0},
      {8'd4, 8'd5, 4'd3, 4'd0, 1'b1, 1'b0},
      {8'd2, 8'd6, 4'd0, 4'd2, 1'b1, 1'b1},
      {8'd1, 8'd1, 4'd0, 4'd0, 1'b1, 1'b0},
      {8'd3, 8'd4, 4'd2, 4'd0, 1'b0, 1'b0},
      {8'd5, 8'd3, 4'd0, 4'd1, 1'b1, 1'b1}
   };

   // monitor state
   bit          mon_en = 0;
   int          mon_lines, mon_ppl, mon_extra;
   logic [23:0] mon_base;
   int          beat_cnt, user_cnt, last_cnt, mon_pos, mon_line;

   task automatic check(input bit ok, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && m_tvalid) begin
         if (mon_en) begin
            int exp_len;
            bit exp_last;
            exp_len  = (mon_line == mon_lines - 1) ? mon_ppl + mon_extra : mon_ppl;
            exp_last = (mon_pos == exp_len - 1);
            check(m_tdata == mon_base + 24'(beat_cnt), "R2 beat data",
                  int'(m_tdata), int'(mon_base + 24'(beat_cnt)));
            check(m_tuser == (beat_cnt == 0), "R4 tuser", int'(m_tuser), int'(beat_cnt == 0));
            check(m_tlast == exp_last, "R5 tlast", int'(m_tlast), int'(exp_last));
            if (exp_last) begin
               mon_pos = 0;
               mon_line++;
            end else mon_pos++;
         end
         beat_cnt++;
         if (m_tuser) user_cnt++;
         if (m_tlast) last_cnt++;
      end
   end

   task automatic drive(input bit fv, input bit lv, input bit dv, input logic [23:0] pix,
                        input bit spare);
      @(negedge clk);
      cl_word = {spare, dv, fv, lv, pix};
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n    = 1'b0;
      cl_word  = '0;
      beat_cnt = 0; user_cnt = 0; last_cnt = 0; mon_pos = 0; mon_line = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_frame(input int lines, input int ppl, input int gap, input int extra,
                            input logic [23:0] base);
      int idx = 0;
      repeat (2) drive(0, 0, 0, 24'h0, 1'b0);
      repeat (2) drive(1, 0, 0, 24'h0, 1'b1);
      for (int l = 0; l < lines; l++) begin
         int n = (l == lines - 1) ? ppl + extra : ppl;
         for (int p = 0; p < n; p++) begin
            if (gap != 0 && (p % gap) == gap - 1) drive(1, 1, 0, 24'hDEAD00, 1'b1);
            drive(1, 1, 1, base + 24'(idx), ~idx[0]);
            idx++;
         end
         if (gap != 0) repeat (2) drive(1, 1, 0, 24'hBEEF00, 1'b0);
         repeat (3) drive(1, 0, 0, 24'h0, 1'b1);
      end
      repeat (6) drive(0, 0, 0, 24'h0, 1'b0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", fails, checks);
         $finish;
      end
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1 reset state
      check(m_tvalid == 0 && m_tuser == 0 && m_tlast == 0, "R1 stream idle", int'(m_tvalid), 0);
      check(line_pixels == 0 && frame_lines == 0, "R1 counts", int'(line_pixels), 0);
      check(!err_line_len && !err_framing && !err_overflow, "R1 flags",
            int'({err_line_len, err_framing, err_overflow}), 0);

      // table-driven frames
      for (int i = 0; i < 6; i++) begin
         int lines = int'(VEC[i][25:18]);
         int ppl   = int'(VEC[i][17:10]);
         int gap   = int'(VEC[i][9:6]);
         int extra = int'(VEC[i][5:2]);
         bit rdy   = VEC[i][1];
         bit elen  = VEC[i][0];
         do_reset();
         m_tready  = rdy;
         mon_lines = lines; mon_ppl = ppl; mon_extra = extra;
         mon_base  = 24'(i * 4096 + 17);
         mon_en    = 1;
         run_frame(lines, ppl, gap, extra, mon_base);
         mon_en = 0;
         check(beat_cnt == lines * ppl + extra, "R3 beat count", beat_cnt, lines * ppl + extra);
         check(user_cnt == 1, "R4 one start marker", user_cnt, 1);
         check(last_cnt == lines, "R5 line markers", last_cnt, lines);
         check(int'(line_pixels) == ppl + extra, "R6 last line length", int'(line_pixels), ppl + extra);
         check(int'(frame_lines) == lines, "R7 frame lines", int'(frame_lines), lines);
         check(err_line_len == elen, "R8 length error", int'(err_line_len), int'(elen));
         check(err_overflow == !rdy, "R10 overflow", int'(err_overflow), int'(!rdy));
         check(err_framing == 0, "R9 no framing error", int'(err_framing), 0);
      end
      m_tready = 1'b1;

      // R9: line envelope without frame envelope; R3: no beat from it
      do_reset();
      repeat (3) drive(0, 1, 1, 24'h123456, 1'b0);
      repeat (5) drive(0, 0, 0, 24'h0, 1'b0);
      check(err_framing == 1, "R9 orphan line flagged", int'(err_framing), 1);
      check(beat_cnt == 0, "R3 no beat outside frame", beat_cnt, 0);

      // R4/R8: two frames without reset; length error clears on the next frame
      do_reset();
      run_frame(2, 4, 0, 1, 24'h000100);
      check(err_line_len == 1, "R8 mismatch in first frame", int'(err_line_len), 1);
      run_frame(3, 4, 0, 0, 24'h000200);
      check(err_line_len == 0, "R8 cleared by next frame", int'(err_line_len), 0);
      check(user_cnt == 2, "R4 start marker per frame", user_cnt, 2);
      check(last_cnt == 5, "R5 line markers two frames", last_cnt, 5);
      check(int'(frame_lines) == 3, "R7 second frame lines", int'(frame_lines), 3);
      check(err_overflow == 0, "R10 no drop with ready", int'(err_overflow), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", fails, checks);
      $finish;
   end

endmodule